// File: doc/BRIEF.md
# Cascaded Interrupt Controller Pair

This block joins two eight-level interrupt controllers, a primary and a secondary, and drives one interrupt line to the processor. The secondary's interrupt output feeds input 2 of the primary. Sixteen request inputs `irq_i[15:0]` go in. Lines 0, 1 and 3–7 belong to the primary, and lines 8–15 are the secondary's levels 0–7. While cascading is enabled, line 2 is taken up by the link and is ignored.

Software writes bytes to four port addresses. Each controller has a command port (primary 20h, secondary A0h) and a data port (primary 21h, secondary A1h). Through these ports it runs a short init sequence that sets a vector base and a link byte, and it sends end-of-interrupt commands.

The processor answers the interrupt with two acknowledge pulses. The first pulse moves the winning request into service. The second returns an 8-bit vector: the base of the controller that owns the winning level, with the 3-bit level number in its low bits. When the primary's winner is the cascade input, the vector comes from the secondary.

Top module: `irq_cascade_pair`

## Requirements
- R1: After reset, `int_o` and `vec_vld_o` are 0. The vector bases are 08h (primary) and 70h (secondary). The link bytes are 04h (primary) and 02h (secondary), so cascading is enabled.
- R2: A rising edge on `irq_i[n]` latches a request. A pending request drives `int_o` high within four clock cycles.
- R3: Priority is fixed, and lower level numbers win. Secondary requests compete as primary level 2, so the service order for all lines at once is 0, 1, 8–15, 3–7.
- R4: Acknowledge takes two `ack_i` pulses. The first moves the winner into in-service and removes its request. The second presents the vector on `vec_o` with `vec_vld_o` high for exactly one cycle.
- R5: The vector is base[7:3] combined with the level number. For example, primary line 1 returns 09h and secondary line 13 (level 5) returns 75h.
- R6: While cascading is enabled, `irq_i[2]` has no effect. Primary level 2 follows the secondary's interrupt, and a win there also moves the secondary's winner into in-service.
- R7: A level in service holds off requests of equal or lower priority. A higher-priority request still raises `int_o` and nests.
- R8: Writing a byte with bit 5 = 1 and bit 4 = 0 to a command port clears that controller's highest-priority in-service bit.
- R9: Writing a byte with bit 4 = 1 to a command port clears requests and in-service bits. The next data-port write sets the base, with bits [2:0] forced to 0. The write after that sets the link byte. Any later data-port writes are ignored.
- R10: Cascading is enabled only when primary link bit 2 = 1 and secondary link bits [2:0] = 2. Otherwise `irq_i[2]` is an ordinary primary level (vector base|2) and secondary requests never reach `int_o`.
- R11: A first acknowledge with nothing pending is spurious. It returns primary base|7 and sets no in-service bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | 16 | Asynchronous request lines, edge sensitive |
| bus_we | input | 1 | Byte write strobe |
| bus_addr | input | 8 | Port address of the write |
| bus_wdata | input | 8 | Written byte |
| ack_i | input | 1 | Acknowledge pulse, two per interrupt |
| int_o | output | 1 | Interrupt to processor |
| vec_o | output | 8 | Vector returned on the second acknowledge |
| vec_vld_o | output | 1 | One-cycle strobe marking `vec_o` valid |

## Verification
The bench builds the block with its default parameters: eight levels per controller, cascade input 2, port addresses 20h/21h/A0h/A1h, and bases 08h/70h. With only fifteen usable lines, every line can be swept one at a time and its vector compared against a value computed arithmetically from the base. All lines can also be raised together to check the complete service order through the cascade. The same small configuration makes it cheap to reprogram both bases and the link bytes. That brings the nesting rules, the spurious acknowledge and the non-cascaded use of line 2 within reach.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int LVL   = 8;
    localparam int LW    = $clog2(LVL);
    localparam int BYTE  = 8;

    typedef enum logic [1:0] {
        INIT_IDLE,
        INIT_BASE,
        INIT_LINK
    } init_e;

    typedef struct packed {
        logic [LVL-1:0]  irr;
        logic [LVL-1:0]  isr;
        logic [BYTE-1:0] base;
        logic [BYTE-1:0] link;
        init_e           st;
    } unit_st_t;

    typedef struct packed {
        logic            ph;
        logic [BYTE-1:0] hold;
        logic [BYTE-1:0] vec;
        logic            vld;
    } top_st_t;
endpackage

// File: rtl/irqc_prio.sv
module irqc_prio
    import irqc_pkg::*;
(
    input  logic [LVL-1:0] vec,
    output logic           any,
    output logic [LW-1:0]  idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = LVL - 1; i >= 0; i--) begin
            if (vec[i]) idx = LW'(i);
        end
    end
endmodule

// File: rtl/irqc_edge.sv
module irqc_edge #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] rise
);
    logic [W-1:0] s1_q, s2_q, prev_q;
    logic [W-1:0] s1_d, s2_d, prev_d;

    always_comb begin
        s1_d   = raw;
        s2_d   = s1_q;
        prev_d = s2_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q   <= '0;
            s2_q   <= '0;
            prev_q <= '0;
        end else begin
            s1_q   <= s1_d;
            s2_q   <= s2_d;
            prev_q <= prev_d;
        end
    end

    assign rise = s2_q & ~prev_q;
endmodule

// File: rtl/irqc_unit.sv
module irqc_unit
    import irqc_pkg::*;
#(
    parameter logic [BYTE-1:0] RST_BASE = 8'h08,
    parameter logic [BYTE-1:0] RST_LINK = 8'h04,
    parameter bit              IS_SEC   = 1'b0,
    parameter int              CASC_LVL = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LVL-1:0]  req_rise,
    input  logic [LVL-1:0]  req_lvl,
    input  logic            cmd_we,
    input  logic            dat_we,
    input  logic [BYTE-1:0] wdata,
    input  logic            take,
    output logic            int_o,
    output logic [LW-1:0]   win_o,
    output logic [LVL-1:0]  isr_o,
    output logic [BYTE-1:0] base_o,
    output logic            casc_o
);
    unit_st_t q, d;
    logic           isr_any;
    logic [LW-1:0]  isr_top;
    logic [LVL-1:0] allowed;
    logic [LVL-1:0] eff;

    irqc_prio u_isr_prio (.vec(q.isr), .any(isr_any), .idx(isr_top));

    always_comb begin
        for (int i = 0; i < LVL; i++) begin
            allowed[i] = !isr_any || (LW'(i) < isr_top);
        end
        eff = (q.irr | req_lvl) & allowed;
    end

    irqc_prio u_req_prio (.vec(eff), .any(int_o), .idx(win_o));

    always_comb begin
        d     = q;
        d.irr = q.irr | req_rise;
        if (take && int_o) begin
            d.isr[win_o] = 1'b1;
            d.irr[win_o] = 1'b0;
        end
        if (cmd_we) begin
            if (wdata[4]) begin
                d.irr = '0;
                d.isr = '0;
                d.st  = INIT_BASE;
            end else if (wdata[5] && isr_any) begin
                d.isr[isr_top] = 1'b0;
            end
        end else if (dat_we) begin
            case (q.st)
                INIT_BASE: begin
                    d.base = {wdata[BYTE-1:LW], {LW{1'b0}}};
                    d.st   = INIT_LINK;
                end
                INIT_LINK: begin
                    d.link = wdata;
                    d.st   = INIT_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.irr  <= '0;
            q.isr  <= '0;
            q.base <= RST_BASE;
            q.link <= RST_LINK;
            q.st   <= INIT_IDLE;
        end else begin
            q <= d;
        end
    end

    assign isr_o  = q.isr;
    assign base_o = q.base;

    generate
        if (IS_SEC) begin : g_sec
            assign casc_o = (q.link[LW-1:0] == LW'(CASC_LVL));
        end else begin : g_pri
            assign casc_o = q.link[CASC_LVL];
        end
    endgenerate

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q.isr & ~$past(q.isr)) <= 1); // R4
    AST_EOI_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !wdata[4] && wdata[5] && isr_any && !take)
        |=> ($countones(q.isr) + 1 == $countones($past(q.isr)))); // R8
    AST_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        (int_o && isr_any) |-> (win_o < isr_top)); // R7
endmodule

// File: rtl/irq_cascade_pair.sv
module irq_cascade_pair
    import irqc_pkg::*;
#(
    parameter logic [BYTE-1:0] PRI_CMD   = 8'h20,
    parameter logic [BYTE-1:0] PRI_DAT   = 8'h21,
    parameter logic [BYTE-1:0] SEC_CMD   = 8'hA0,
    parameter logic [BYTE-1:0] SEC_DAT   = 8'hA1,
    parameter logic [BYTE-1:0] PRI_BASE0 = 8'h08,
    parameter logic [BYTE-1:0] SEC_BASE0 = 8'h70,
    parameter int              CASC_LVL  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2*LVL-1:0]  irq_i,
    input  logic              bus_we,
    input  logic [BYTE-1:0]   bus_addr,
    input  logic [BYTE-1:0]   bus_wdata,
    input  logic              ack_i,
    output logic              int_o,
    output logic [BYTE-1:0]   vec_o,
    output logic              vec_vld_o
);
    localparam logic [BYTE-1:0] PRI_LINK0 = BYTE'(1) << CASC_LVL;
    localparam logic [BYTE-1:0] SEC_LINK0 = BYTE'(CASC_LVL);

    top_st_t q, d;
    logic [2*LVL-1:0] rise;
    logic [LVL-1:0]   p_rise, p_lvl, p_isr, s_isr;
    logic             p_int, s_int, p_casc, s_casc, casc_on;
    logic [LW-1:0]    p_win, s_win;
    logic [BYTE-1:0]  p_base, s_base, vec_sel;
    logic             take, s_take, p_win_casc;

    irqc_edge #(.W(2*LVL)) u_edge (.clk(clk), .rst_n(rst_n), .raw(irq_i), .rise(rise));

    assign casc_on    = p_casc && s_casc;
    assign p_win_casc = casc_on && (p_win == LW'(CASC_LVL));
    assign take       = ack_i && !q.ph;
    assign s_take     = take && p_int && p_win_casc;

    always_comb begin
        p_rise = rise[LVL-1:0];
        p_lvl  = '0;
        if (casc_on) begin
            p_rise[CASC_LVL] = 1'b0;
            p_lvl[CASC_LVL]  = s_int;
        end
    end

    irqc_unit #(.RST_BASE(PRI_BASE0), .RST_LINK(PRI_LINK0), .IS_SEC(1'b0), .CASC_LVL(CASC_LVL)) u_pri (
        .clk(clk), .rst_n(rst_n), .req_rise(p_rise), .req_lvl(p_lvl),
        .cmd_we(bus_we && bus_addr == PRI_CMD), .dat_we(bus_we && bus_addr == PRI_DAT),
        .wdata(bus_wdata), .take(take), .int_o(p_int), .win_o(p_win),
        .isr_o(p_isr), .base_o(p_base), .casc_o(p_casc));

    irqc_unit #(.RST_BASE(SEC_BASE0), .RST_LINK(SEC_LINK0), .IS_SEC(1'b1), .CASC_LVL(CASC_LVL)) u_sec (
        .clk(clk), .rst_n(rst_n), .req_rise(rise[2*LVL-1:LVL]), .req_lvl('0),
        .cmd_we(bus_we && bus_addr == SEC_CMD), .dat_we(bus_we && bus_addr == SEC_DAT),
        .wdata(bus_wdata), .take(s_take), .int_o(s_int), .win_o(s_win),
        .isr_o(s_isr), .base_o(s_base), .casc_o(s_casc));

    always_comb begin
        if (!p_int)          vec_sel = {p_base[BYTE-1:LW], {LW{1'b1}}};
        else if (p_win_casc) vec_sel = {s_base[BYTE-1:LW], s_win};
        else                 vec_sel = {p_base[BYTE-1:LW], p_win};
    end

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        if (ack_i) begin
            if (!q.ph) begin
                d.hold = vec_sel;
                d.ph   = 1'b1;
            end else begin
                d.vec = q.hold;
                d.vld = 1'b1;
                d.ph  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign int_o     = p_int;
    assign vec_o     = q.vec;
    assign vec_vld_o = q.vld;

    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld_o |=> !vec_vld_o); // R4
    AST_CASC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(p_isr[CASC_LVL]) && $past(casc_on)) |-> (s_isr != $past(s_isr))); // R6
    AST_SPURIOUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !p_int) |=> (p_isr == $past(p_isr))); // R11
endmodule

// File: tb/irq_cascade_pair_tb_top.sv
module irq_cascade_pair_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_i = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        ack_i = 1'b0;
    logic        int_o;
    logic [7:0]  vec_o;
    logic        vec_vld_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int pb = 8'h08;
    int sb = 8'h70;

    always #2.5 clk = ~clk;

    irq_cascade_pair dut_i (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ack_i(ack_i),
        .int_o(int_o), .vec_o(vec_o), .vec_vld_o(vec_vld_o));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        tick(1);
        bus_we = 1'b0;
    endtask

    task automatic pulse(input int n);
        irq_i[n] = 1'b1;
        tick(4);
        irq_i[n] = 1'b0;
        tick(2);
    endtask

    task automatic ack2(output logic [7:0] v, output logic vld);
        ack_i = 1'b1; tick(1);
        ack_i = 1'b0; tick(1);
        ack_i = 1'b1; tick(1);
        v = vec_o; vld = vec_vld_o;
        ack_i = 1'b0; tick(1);
    endtask

    function automatic int exp_vec(input int n);
        return (n < 8) ? (pb + n) : (sb + n - 8);
    endfunction

    task automatic eoi(input int n);
        if (n >= 8) wr(8'hA0, 8'h20);
        wr(8'h20, 8'h20);
        tick(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic vld;
        tick(3);
        check(int_o == 1'b0, "R1 int after reset", int_o, 0);
        check(vec_vld_o == 1'b0, "R1 vld after reset", vec_vld_o, 0);
        rst_n = 1'b1;
        tick(2);

        // R2 R4 R5: sweep every usable line
        for (int n = 0; n < 16; n++) begin
            if (n == 2) continue;
            pulse(n);
            check(int_o == 1'b1, "R2 request raises int", int_o, 1);
            ack2(v, vld);
            check(vld == 1'b1, "R4 vector strobe", vld, 1);
            check(v == 8'(exp_vec(n)), "R5 vector (R1 default base)", v, exp_vec(n));
            if (n == 13) check(v == 8'h75, "R5 secondary level 5", v, 8'h75);
            if (n == 1)  check(v == 8'h09, "R5 primary level 1", v, 8'h09);
            check(vec_vld_o == 1'b0, "R4 strobe one cycle", vec_vld_o, 0);
            check(int_o == 1'b0, "R4 request removed", int_o, 0);
            eoi(n);
            check(int_o == 1'b0, "R8 idle after eoi", int_o, 0);
        end

        // R6: line 2 ignored while cascading
        pulse(2);
        check(int_o == 1'b0, "R6 line 2 ignored", int_o, 0);

        // R3: all lines at once
        irq_i = 16'hFFFB;
        tick(4);
        irq_i = '0;
        tick(2);
        for (int k = 0; k < 15; k++) begin
            int n;
            n = (k < 2) ? k : ((k < 10) ? k + 6 : k - 7);
            ack2(v, vld);
            check(v == 8'(exp_vec(n)), "R3 service order", v, exp_vec(n));
            eoi(n);
        end
        check(int_o == 1'b0, "R3 all served", int_o, 0);

        // R7: nesting
        pulse(3);
        ack2(v, vld);
        check(v == 8'h0B, "R7 level 3 served", v, 8'h0B);
        pulse(5);
        check(int_o == 1'b0, "R7 lower held off", int_o, 0);
        pulse(1);
        check(int_o == 1'b1, "R7 higher nests", int_o, 1);
        ack2(v, vld);
        check(v == 8'h09, "R7 nested vector", v, 8'h09);
        eoi(1);
        check(int_o == 1'b0, "R8 pops only level 1", int_o, 0);
        eoi(3);
        check(int_o == 1'b1, "R8 pops level 3, 5 released", int_o, 1);
        ack2(v, vld);
        check(v == 8'h0D, "R7 released vector", v, 8'h0D);
        eoi(5);

        // R11: spurious acknowledge
        ack2(v, vld);
        check(v == 8'h0F, "R11 spurious vector", v, 8'h0F);
        pulse(4);
        ack2(v, vld);
        check(v == 8'h0C, "R11 no stale in-service", v, 8'h0C);
        eoi(4);

        // R9: reprogram both controllers
        wr(8'h20, 8'h11); wr(8'h21, 8'h43); wr(8'h21, 8'h04);
        wr(8'hA0, 8'h11); wr(8'hA1, 8'h8A); wr(8'hA1, 8'h02);
        wr(8'h21, 8'hFF); wr(8'hA1, 8'hFF);
        pb = 8'h40; sb = 8'h88;
        tick(1);
        pulse(6);
        ack2(v, vld);
        check(v == 8'h46, "R9 new primary base", v, 8'h46);
        eoi(6);
        pulse(12);
        ack2(v, vld);
        check(v == 8'h8C, "R9 new secondary base", v, 8'h8C);
        eoi(12);

        // R10: cascade disabled on primary
        wr(8'h20, 8'h11); wr(8'h21, 8'h20); wr(8'h21, 8'h00);
        pb = 8'h20;
        tick(1);
        pulse(2);
        check(int_o == 1'b1, "R10 line 2 ordinary", int_o, 1);
        ack2(v, vld);
        check(v == 8'h22, "R10 line 2 vector", v, 8'h22);
        eoi(2);
        pulse(9);
        check(int_o == 1'b0, "R10 secondary not routed", int_o, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule